// File: doc/BRIEF.md
# Stack Window Pointer Controller

This block manages the bookkeeping of a stack cache that keeps the top of a downward-growing stack in a small ring buffer. Three word-address pointers describe the window. The top pointer marks the lowest live stack word. The bound pointer marks the end of the cached region; words at and above it live only in main memory. The dirty pointer splits the cached words into two parts. Words below it may differ from memory, and words from it up to the bound are known to match memory. Because of this split, shrinking the window can sometimes drop clean words without any memory write.

The pipeline issues three control operations: reserve k words, free k words and ensure k words are cached. It also issues loads and stores at a word offset from the top pointer, and these always complete at fixed latency. When a reserve must write dirty words back, or an ensure must bring words in, the controller raises a single memory request. The request carries a start address, a length in words and a direction. The controller then moves one word per data beat between the ring buffer and the memory port. It holds the pipeline stalled until the last beat.

Top module: `stack_window_ctrl`

## Requirements
- R1: After reset, the top, bound and dirty pointers all equal the base address (0x8000 by default), stall is low and no memory request is raised.
- R2: Whenever no transfer is in flight, top ≤ dirty ≤ bound holds and bound − top never exceeds the ring size of 64 words.
- R3: A reserve of k (op_code 2'b00, k ≤ 64) lowers top by k. If dirty − new top still fits in 64 words but bound − new top does not, bound becomes new top + 64 at once, with no memory request and no stall.
- R4: If a reserve leaves dirty − new top above 64, the block issues a write request (mem_wr = 1). It starts at new top + 64 and has length dirty − (new top + 64). The words go out in ascending address order on successive beats. After the last beat, bound and dirty both equal new top + 64.
- R5: A free of k (op_code 2'b01) raises top by k, and clamps bound and dirty up to the new top if they fall below it. It never raises a request or a stall.
- R6: An ensure of k (op_code 2'b10) with bound − top < k issues a read request (mem_wr = 0). The request starts at bound and has length top + k − bound. Each beat's mem_rdata is stored in the ring, and bound becomes top + k after the last beat. Dirty never changes during the fill. When bound − top ≥ k, the ensure does nothing.
- R7: A store writes st_data to ring slot (top + st_off) mod 64. If that address is at or above dirty, dirty moves to address + 1, and likewise bound. A load returns ring slot (top + ld_off) mod 64 on ld_data one cycle later.
- R8: Stall rises in the cycle after a transferring operation is accepted and falls in the cycle after the final beat. mem_req stays high with address, length and direction unchanged until mem_ack.
- R9: Control operations, loads and stores presented while stall is high are ignored, and so is a store presented together with op_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Control operation present |
| op_code | input | 2 | 00 reserve, 01 free, 10 ensure, 11 none |
| op_k | input | 7 | Word count k, at most 64 |
| ld_en | input | 1 | Stack load strobe |
| ld_off | input | 6 | Load word offset from top |
| ld_data | output | 32 | Load result, one cycle after ld_en |
| st_en | input | 1 | Stack store strobe |
| st_off | input | 6 | Store word offset from top |
| st_data | input | 32 | Store data |
| stall | output | 1 | Pipeline hold during a transfer |
| top_ptr | output | 16 | Current top pointer |
| bound_ptr | output | 16 | Current bound pointer |
| dirty_ptr | output | 16 | Current dirty pointer |
| mem_req | output | 1 | Memory transfer request |
| mem_ack | input | 1 | Request accepted |
| mem_wr | output | 1 | 1 write to memory (spill), 0 read (fill) |
| mem_addr | output | 16 | Transfer start word address |
| mem_len | output | 7 | Transfer length in words |
| mem_beat | input | 1 | One data word moves this cycle |
| mem_wdata | output | 32 | Spill word for the current beat |
| mem_rdata | input | 32 | Fill word for the current beat |

## Verification
Some properties are checked on every cycle. The pointer ordering and the occupancy bound are checked whenever the block is idle. The request fields must hold steady until acknowledged. Stall must cover every request and top must stay frozen while stalled. A free must never stall, and the dirty pointer must stay fixed through a fill. A spill must always leave bound and dirty meeting at top + 64. Other behaviours only show up in the bench scenarios. These are the exact start addresses and lengths chosen for spills and fills, and the word order and contents on the beats. They also include the data wrapping through the ring modulo 64, the store that pushes dirty upward, the silent bound clip on reserve, and the way operations and stores offered during a stall are dropped.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    SC_OP_RESERVE = 2'b00,
    SC_OP_FREE    = 2'b01,
    SC_OP_ENSURE  = 2'b10,
    SC_OP_NONE    = 2'b11
  } sc_op_e;

  typedef enum logic [1:0] {
    XS_IDLE = 2'b00,
    XS_REQ  = 2'b01,
    XS_BEAT = 2'b10
  } xfer_state_e;
endpackage

// File: rtl/sc_ring.sv
module sc_ring #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx_a,
  output logic [DW-1:0] rdata_a,
  input  logic [IW-1:0] ridx_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] slot_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slot_q[widx] <= wdata;
  end

  assign rdata_a = slot_q[ridx_a];
  assign rdata_b = slot_q[ridx_b];
endmodule

// File: rtl/sc_op_plan.sv
module sc_op_plan import sc_pkg::*; #(
  parameter int AW       = 16,
  parameter int SC_WORDS = 64,
  localparam int IW      = $clog2(SC_WORDS),
  localparam int KW      = IW + 1,
  localparam int LW      = IW + 1
) (
  input  logic [AW-1:0] top_q,
  input  logic [AW-1:0] bnd_q,
  input  logic [AW-1:0] drt_q,
  input  sc_op_e        op,
  input  logic [KW-1:0] k,
  output logic [AW-1:0] top_nx,
  output logic [AW-1:0] bnd_nx,
  output logic [AW-1:0] drt_nx,
  output logic          need,
  output logic          need_wr,
  output logic [AW-1:0] need_addr,
  output logic [LW-1:0] need_len,
  output logic [AW-1:0] fin_bnd,
  output logic [AW-1:0] fin_drt
);
  localparam logic [AW-1:0] SCA = AW'(SC_WORDS);

  logic [AW-1:0] k_ext;
  logic [AW-1:0] dn_top;
  logic [AW-1:0] dn_lim;
  logic [AW-1:0] up_top;

  assign k_ext  = AW'(k);
  assign dn_top = top_q - k_ext;
  assign dn_lim = dn_top + SCA;
  assign up_top = top_q + k_ext;

  always_comb begin
    top_nx    = top_q;
    bnd_nx    = bnd_q;
    drt_nx    = drt_q;
    need      = 1'b0;
    need_wr   = 1'b0;
    need_addr = '0;
    need_len  = '0;
    fin_bnd   = bnd_q;
    fin_drt   = drt_q;
    unique case (op)
      SC_OP_RESERVE: begin
        top_nx = dn_top;
        if ((drt_q - dn_top) > SCA) begin
          need      = 1'b1;
          need_wr   = 1'b1;
          need_addr = dn_lim;
          need_len  = LW'(drt_q - dn_lim);
          fin_bnd   = dn_lim;
          fin_drt   = dn_lim;
        end else if ((bnd_q - dn_top) > SCA) begin
          bnd_nx = dn_lim;
        end
      end
      SC_OP_FREE: begin
        top_nx = up_top;
        if (bnd_q < up_top) bnd_nx = up_top;
        if (drt_q < up_top) drt_nx = up_top;
      end
      SC_OP_ENSURE: begin
        if ((bnd_q - top_q) < k_ext) begin
          need      = 1'b1;
          need_addr = bnd_q;
          need_len  = LW'(up_top - bnd_q);
          fin_bnd   = up_top;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_xfer_seq.sv
module sc_xfer_seq import sc_pkg::*; #(
  parameter int AW = 16,
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_wr,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_len,
  input  logic          mem_ack,
  input  logic          mem_beat,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [LW-1:0] mem_len,
  output logic [AW-1:0] cur_addr,
  output logic          beat_fire,
  output logic          last_beat
);
  xfer_state_e   state_q, state_d;
  logic          wr_q, wr_d;
  logic [AW-1:0] base_q, base_d;
  logic [LW-1:0] len_q, len_d;
  logic [AW-1:0] cur_q, cur_d;
  logic [LW-1:0] left_q, left_d;
  logic          seq_en;

  assign busy      = (state_q != XS_IDLE);
  assign mem_req   = (state_q == XS_REQ);
  assign beat_fire = (state_q == XS_BEAT) && mem_beat;
  assign last_beat = beat_fire && (left_q == LW'(1));
  assign mem_wr    = wr_q;
  assign mem_addr  = base_q;
  assign mem_len   = len_q;
  assign cur_addr  = cur_q;

  assign seq_en = ((state_q == XS_IDLE) && start) ||
                  ((state_q == XS_REQ) && mem_ack) || beat_fire;

  always_comb begin
    state_d = state_q;
    wr_d    = wr_q;
    base_d  = base_q;
    len_d   = len_q;
    cur_d   = cur_q;
    left_d  = left_q;
    unique case (state_q)
      XS_IDLE: begin
        if (start) begin
          state_d = XS_REQ;
          wr_d    = start_wr;
          base_d  = start_addr;
          len_d   = start_len;
          cur_d   = start_addr;
          left_d  = start_len;
        end
      end
      XS_REQ: begin
        if (mem_ack) state_d = XS_BEAT;
      end
      XS_BEAT: begin
        if (mem_beat) begin
          cur_d  = cur_q + AW'(1);
          left_d = left_q - LW'(1);
          if (left_q == LW'(1)) state_d = XS_IDLE;
        end
      end
      default: state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      wr_q    <= 1'b0;
      base_q  <= '0;
      len_q   <= '0;
      cur_q   <= '0;
      left_q  <= '0;
    end else if (seq_en) begin
      state_q <= state_d;
      wr_q    <= wr_d;
      base_q  <= base_d;
      len_q   <= len_d;
      cur_q   <= cur_d;
      left_q  <= left_d;
    end
  end

  // R8: request fields frozen until accepted
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_wr)));

  // R4 / R6: a launched transfer always carries at least one word
  p_len_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |-> (start_len != '0));
endmodule

// File: rtl/stack_window_ctrl.sv
module stack_window_ctrl import sc_pkg::*; #(
  parameter int          AW        = 16,
  parameter int          DW        = 32,
  parameter int          SC_WORDS  = 64,
  parameter int unsigned BASE_WORD = 32'h8000,
  localparam int         IW        = $clog2(SC_WORDS),
  localparam int         KW        = IW + 1,
  localparam int         LW        = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_code,
  input  logic [KW-1:0] op_k,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_off,
  output logic [DW-1:0] ld_data,
  input  logic          st_en,
  input  logic [IW-1:0] st_off,
  input  logic [DW-1:0] st_data,
  output logic          stall,
  output logic [AW-1:0] top_ptr,
  output logic [AW-1:0] bound_ptr,
  output logic [AW-1:0] dirty_ptr,
  output logic          mem_req,
  input  logic          mem_ack,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [LW-1:0] mem_len,
  input  logic          mem_beat,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam logic [AW-1:0] BASE = AW'(BASE_WORD);
  localparam logic [AW-1:0] SCA  = AW'(SC_WORDS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  sc_op_e        op_sel;
  logic          op_go, st_go, ld_go;
  logic [AW-1:0] top_q, bnd_q, drt_q;
  logic [AW-1:0] top_d, bnd_d, drt_d;
  logic [AW-1:0] pend_bnd_q, pend_drt_q;
  logic          ptr_en, pend_en;
  logic [AW-1:0] st_addr, ld_addr;
  logic [DW-1:0] ld_q;

  logic [AW-1:0] pl_top, pl_bnd, pl_drt, pl_addr, pl_fin_bnd, pl_fin_drt;
  logic          pl_need, pl_wr;
  logic [LW-1:0] pl_len;

  logic          xf_busy, xf_fire, xf_last, xf_wr;
  logic [AW-1:0] xf_cur;

  logic          ring_we;
  logic [IW-1:0] ring_widx;
  logic [DW-1:0] ring_wdata, ring_rd_ld;

  assign op_sel  = sc_op_e'(op_code);
  assign op_go   = op_valid && !stall && (op_sel != SC_OP_NONE);
  assign st_go   = st_en && !stall && !op_valid;
  assign ld_go   = ld_en && !stall;
  assign st_addr = top_q + AW'(st_off);
  assign ld_addr = top_q + AW'(ld_off);

  sc_op_plan #(.AW(AW), .SC_WORDS(SC_WORDS)) u_plan (
    .top_q(top_q), .bnd_q(bnd_q), .drt_q(drt_q), .op(op_sel), .k(op_k),
    .top_nx(pl_top), .bnd_nx(pl_bnd), .drt_nx(pl_drt),
    .need(pl_need), .need_wr(pl_wr), .need_addr(pl_addr), .need_len(pl_len),
    .fin_bnd(pl_fin_bnd), .fin_drt(pl_fin_drt)
  );

  sc_xfer_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_q_n),
    .start(op_go && pl_need), .start_wr(pl_wr), .start_addr(pl_addr), .start_len(pl_len),
    .mem_ack(mem_ack), .mem_beat(mem_beat),
    .busy(xf_busy), .mem_req(mem_req), .mem_wr(xf_wr), .mem_addr(mem_addr), .mem_len(mem_len),
    .cur_addr(xf_cur), .beat_fire(xf_fire), .last_beat(xf_last)
  );

  assign stall  = xf_busy;
  assign mem_wr = xf_wr;

  // ring slot = word address modulo ring size (power of two)
  assign ring_we    = st_go || (xf_fire && !xf_wr);
  assign ring_widx  = st_go ? st_addr[IW-1:0] : xf_cur[IW-1:0];
  assign ring_wdata = st_go ? st_data : mem_rdata;

  sc_ring #(.DW(DW), .DEPTH(SC_WORDS)) u_ring (
    .clk(clk), .we(ring_we), .widx(ring_widx), .wdata(ring_wdata),
    .ridx_a(ld_addr[IW-1:0]), .rdata_a(ring_rd_ld),
    .ridx_b(xf_cur[IW-1:0]), .rdata_b(mem_wdata)
  );

  always_comb begin
    top_d = top_q;
    bnd_d = bnd_q;
    drt_d = drt_q;
    if (op_go) begin
      top_d = pl_top;
      bnd_d = pl_bnd;
      drt_d = pl_drt;
    end else if (st_go) begin
      if (st_addr >= drt_q) drt_d = st_addr + AW'(1);
      if (st_addr >= bnd_q) bnd_d = st_addr + AW'(1);
    end
    if (xf_last) begin
      bnd_d = pend_bnd_q;
      drt_d = pend_drt_q;
    end
  end

  assign ptr_en  = op_go || st_go || xf_last;
  assign pend_en = op_go && pl_need;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      top_q <= BASE;
      bnd_q <= BASE;
      drt_q <= BASE;
    end else if (ptr_en) begin
      top_q <= top_d;
      bnd_q <= bnd_d;
      drt_q <= drt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pend_bnd_q <= '0;
      pend_drt_q <= '0;
    end else if (pend_en) begin
      pend_bnd_q <= pl_fin_bnd;
      pend_drt_q <= pl_fin_drt;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)   ld_q <= '0;
    else if (ld_go) ld_q <= ring_rd_ld;
  end

  assign ld_data   = ld_q;
  assign top_ptr   = top_q;
  assign bound_ptr = bnd_q;
  assign dirty_ptr = drt_q;

  // R2: window ordering and size while idle
  p_window_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !stall |-> (((drt_q - top_q) <= (bnd_q - top_q)) && ((bnd_q - top_q) <= SCA)));

  // R8: any outstanding request is covered by stall
  p_req_stall_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_req |-> stall);

  // R9: top pointer frozen while stalled
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    stall |=> $stable(top_q));

  // R5: free never stalls
  p_free_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_go && op_sel == SC_OP_FREE) |=> (!stall && !mem_req));

  // R6: dirty pointer untouched through a fill
  p_fill_dirty_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (stall && !mem_wr) |=> $stable(drt_q));

  // R4: a finished spill leaves bound and dirty at top + ring size
  p_spill_end_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (xf_last && mem_wr) |=> ((bnd_q == drt_q) && ((bnd_q - top_q) == SCA)));
endmodule

// File: tb/stack_window_ctrl_test.sv
module stack_window_ctrl_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int KW = 7;
  localparam int LW = 7;
  localparam int IW = 6;
  localparam logic [AW-1:0] BASE = 16'h8000;
  localparam logic [AW-1:0] SCA  = 16'd64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          op_valid;
  logic [1:0]    op_code;
  logic [KW-1:0] op_k;
  logic          ld_en;
  logic [IW-1:0] ld_off;
  logic [DW-1:0] ld_data;
  logic          st_en;
  logic [IW-1:0] st_off;
  logic [DW-1:0] st_data;
  logic          stall;
  logic [AW-1:0] top_ptr, bound_ptr, dirty_ptr;
  logic          mem_req, mem_ack, mem_wr, mem_beat;
  logic [AW-1:0] mem_addr;
  logic [LW-1:0] mem_len;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  stack_window_ctrl uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_k(op_k),
    .ld_en(ld_en), .ld_off(ld_off), .ld_data(ld_data),
    .st_en(st_en), .st_off(st_off), .st_data(st_data),
    .stall(stall), .top_ptr(top_ptr), .bound_ptr(bound_ptr), .dirty_ptr(dirty_ptr),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_beat(mem_beat), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [LW-1:0] len;
  } req_t;

  req_t          exp_q[$];
  int            checks = 0;
  int            errors = 0;
  int            ack_delay = 0;
  bit            done = 0;
  logic [AW-1:0] m_top, m_bnd, m_drt;
  logic [DW-1:0] m_ring [64];

  function automatic logic [DW-1:0] fill_word(input logic [AW-1:0] a);
    return {16'hF111, a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic chk_ptrs(input string req);
    chk(top_ptr == m_top, req, "top pointer", 64'(top_ptr), 64'(m_top));
    chk(bound_ptr == m_bnd, req, "bound pointer", 64'(bound_ptr), 64'(m_bnd));
    chk(dirty_ptr == m_drt, req, "dirty pointer", 64'(dirty_ptr), 64'(m_drt));
  endtask

  // driver: computes expected window and queues expected transfers
  task automatic do_op(input logic [1:0] code, input int k, input string req);
    logic [AW-1:0] s;
    bit xfer = 0;
    if (code == 2'b00) begin
      s = m_top - AW'(k);
      if ((m_drt - s) > SCA) begin
        exp_q.push_back('{wr: 1'b1, addr: s + SCA, len: LW'(m_drt - (s + SCA))});
        m_bnd = s + SCA; m_drt = s + SCA; xfer = 1;
      end else if ((m_bnd - s) > SCA) m_bnd = s + SCA;
      m_top = s;
    end else if (code == 2'b01) begin
      m_top = m_top + AW'(k);
      if (m_bnd < m_top) m_bnd = m_top;
      if (m_drt < m_top) m_drt = m_top;
    end else if (code == 2'b10) begin
      if ((m_bnd - m_top) < AW'(k)) begin
        exp_q.push_back('{wr: 1'b0, addr: m_bnd, len: LW'(m_top + AW'(k) - m_bnd)});
        m_bnd = m_top + AW'(k); xfer = 1;
      end
    end
    op_valid = 1; op_code = code; op_k = KW'(k);
    @(negedge clk);
    op_valid = 0;
    chk(stall == xfer, req, "stall after operation", 64'(stall), 64'(xfer));
    while (stall) @(negedge clk);
    chk_ptrs(req);
  endtask

  task automatic do_store(input int off, input logic [DW-1:0] d, input string req);
    logic [AW-1:0] a;
    a = m_top + AW'(off);
    st_en = 1; st_off = IW'(off); st_data = d;
    @(negedge clk);
    st_en = 0;
    m_ring[a[IW-1:0]] = d;
    if (a >= m_drt) m_drt = a + 1;
    if (a >= m_bnd) m_bnd = a + 1;
    chk_ptrs(req);
  endtask

  task automatic do_load(input int off, input string req);
    logic [AW-1:0] a;
    a = m_top + AW'(off);
    ld_en = 1; ld_off = IW'(off);
    @(negedge clk);
    ld_en = 0;
    chk(ld_data == m_ring[a[IW-1:0]], req, "load data", 64'(ld_data), 64'(m_ring[a[IW-1:0]]));
  endtask

  // monitor / memory model: pops expected transfers and compares
  initial begin
    req_t e;
    logic [AW-1:0] a;
    logic [AW-1:0] hold_addr;
    mem_ack = 0; mem_beat = 0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        if (exp_q.size() == 0) begin
          chk(0, "R3", "unexpected memory request", 64'(mem_addr), 64'(0));
          e = '{wr: mem_wr, addr: mem_addr, len: mem_len};
        end else begin
          e = exp_q.pop_front();
          chk(mem_wr == e.wr, e.wr ? "R4" : "R6", "direction", 64'(mem_wr), 64'(e.wr));
          chk(mem_addr == e.addr, e.wr ? "R4" : "R6", "start address", 64'(mem_addr), 64'(e.addr));
          chk(mem_len == e.len, e.wr ? "R4" : "R6", "length", 64'(mem_len), 64'(e.len));
        end
        hold_addr = mem_addr;
        for (int d = 0; d < ack_delay; d++) begin
          @(negedge clk);
          chk(mem_req && mem_addr == hold_addr, "R8", "request held before ack",
              64'({mem_req, mem_addr}), 64'({1'b1, hold_addr}));
        end
        mem_ack = 1;
        @(negedge clk);
        mem_ack = 0;
        for (int i = 0; i < int'(e.len); i++) begin
          a = e.addr + AW'(i);
          mem_beat = 1;
          if (e.wr) begin
            chk(mem_wdata == m_ring[a[IW-1:0]], "R4", "spill word",
                64'(mem_wdata), 64'(m_ring[a[IW-1:0]]));
          end else begin
            mem_rdata = fill_word(a);
            m_ring[a[IW-1:0]] = fill_word(a);
          end
          @(negedge clk);
        end
        mem_beat = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R8", "watchdog expired", 64'(0), 64'(1));
    finish_run();
  end

  initial begin
    rst_n = 0; op_valid = 0; op_code = 2'b11; op_k = '0;
    ld_en = 0; ld_off = '0; st_en = 0; st_off = '0; st_data = '0;
    m_top = BASE; m_bnd = BASE; m_drt = BASE;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk_ptrs("R1");
    chk(!stall && !mem_req, "R1", "idle after reset", 64'({stall, mem_req}), 64'(0));

    // fill every ring slot with known data (R7)
    do_op(2'b00, 64, "R3");
    for (int i = 0; i < 64; i++) do_store(i, {16'hC0DE, m_top + AW'(i)}, "R7");
    do_load(5, "R7");
    do_load(63, "R7");
    do_op(2'b01, 64, "R5");

    // plain reserve, stores below dirty
    do_op(2'b00, 20, "R3");
    for (int i = 0; i < 20; i++) do_store(i, {16'hA000, m_top + AW'(i)}, "R7");
    do_load(3, "R7");

    // reserve that spills dirty words (R4)
    do_op(2'b00, 50, "R4");
    chk(bound_ptr - top_ptr == SCA, "R2", "occupancy at limit", 64'(bound_ptr - top_ptr), 64'(SCA));

    // free without transfer (R5)
    do_op(2'b01, 50, "R5");

    // ensure that fills (R6), then loads through the ring
    do_op(2'b10, 20, "R6");
    do_load(14, "R6");
    do_load(19, "R6");
    do_load(0, "R7");

    // ensure already satisfied (R6)
    do_op(2'b10, 10, "R6");

    // store above dirty moves it (R7)
    do_store(16, 32'h1234_5678, "R7");
    chk(dirty_ptr == top_ptr + 17, "R7", "dirty after store", 64'(dirty_ptr), 64'(top_ptr + 17));

    // free past bound clamps both pointers (R5)
    do_op(2'b01, 30, "R5");

    // large fill, then reserve that only clips bound (R3)
    do_op(2'b10, 40, "R6");
    do_op(2'b00, 30, "R3");
    chk(!mem_req, "R3", "no request on clip", 64'(mem_req), 64'(0));

    // long spill with delayed ack; offer work during the stall (R8, R9)
    ack_delay = 3;
    begin
      logic [AW-1:0] s;
      s = m_top - 64;
      exp_q.push_back('{wr: 1'b1, addr: s + SCA, len: LW'(m_drt - (s + SCA))});
      m_bnd = s + SCA; m_drt = s + SCA; m_top = s;
    end
    op_valid = 1; op_code = 2'b00; op_k = 7'd64;
    @(negedge clk);
    chk(stall == 1, "R8", "stall after spill start", 64'(stall), 64'(1));
    op_code = 2'b01; op_k = 7'd10;
    st_en = 1; st_off = '0; st_data = 32'hDEAD_BEEF;
    @(negedge clk);
    chk(stall && mem_req, "R8", "stall with request pending", 64'({stall, mem_req}), 64'(3));
    while (stall) @(negedge clk);
    op_valid = 0; st_en = 0;
    chk_ptrs("R9");
    do_load(0, "R9");
    ack_delay = 0;

    // store presented with an operation is dropped (R9)
    op_valid = 1; op_code = 2'b11; st_en = 1; st_off = 6'd1; st_data = 32'hBAD0_0001;
    @(negedge clk);
    op_valid = 0; st_en = 0;
    do_load(1, "R9");
    chk_ptrs("R9");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "all expected transfers seen", 64'(exp_q.size()), 64'(0));
    finish_run();
  end
endmodule